// File: doc/BRIEF.md
# Counted Pipelined Loop Branch Controller

This block makes the taken or fall-through decision for the closing branch of a counted loop. It keeps two down-counters. The trip counter holds the remaining kernel iterations. The drain counter holds the number of pipeline stages that still have to empty once new iterations stop entering. Each evaluation strobe picks one outcome and updates the counters. It also produces the value for the topmost rotating predicate and a one-cycle rotate pulse for the register rename logic.

In pipelined mode the branch keeps being taken after the trip count runs out, so that the stages already in flight can finish. During that drain it writes 0 into the top predicate, and that 0 shifts down into the first stage enable and stops new iterations from starting. A plain counted mode is also provided. It only counts the trip counter down and never rotates. The block has a small internal model of the rotation: a base register that steps down by one on each rotate, and a stage-enable shift chain. Both are brought out so the feedback path can be observed.

Top module: `loop_branch_ctl`

## Requirements
- R1: While rst_n is low at a clock edge, the trip counter, drain counter, rotation base and stage enables become 0, and br_done, br_taken, rot_pulse and top_pred become 0.
- R2: A pipelined evaluation (br_mode = 1) with a nonzero trip counter decrements the trip counter by one and leaves the drain counter unchanged. In the following cycle br_done = 1, br_taken = 1, rot_pulse = 1 and top_pred = 1.
- R3: A pipelined evaluation with a zero trip counter and a drain counter above 1 decrements the drain counter. The result is taken, rotates, and writes top_pred = 0.
- R4: A pipelined evaluation with a zero trip counter and a drain counter of 1 or 0 falls through (br_taken = 0) but still rotates with top_pred = 0. The drain counter goes to 0 and never wraps below 0.
- R5: A simple evaluation (br_mode = 0) with a nonzero trip counter decrements it and is taken. With a zero trip counter it falls through. Simple mode never rotates, never changes the drain counter and always gives top_pred = 0.
- R6: When lc_load_en or ec_load_en is high in the same cycle as br_go, the loads are applied and the evaluation is discarded. In that case br_done stays 0 and no counter decrements.
- R7: The rotation base (RB_W bits, two's complement) decreases by one, modulo 2^RB_W, on every rotate. Loading 3 into the trip counter and 4 into the drain counter gives 7 pipelined evaluations: 6 taken, then a fall-through. Both counters end at 0 and the base ends at -7.
- R8: On every rotate, stage_en shifts up by one position (bit i takes the old bit i-1) and bit 0 takes the top_pred value written by that evaluation.
- R9: Without br_go, br_done, br_taken and rot_pulse stay 0 and the counters, base and stage enables hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| br_go | input | 1 | Branch evaluation strobe |
| br_mode | input | 1 | 0 = simple counted, 1 = pipelined counted |
| lc_load_en | input | 1 | Load the trip counter |
| lc_load_val | input | LC_W (64) | Trip counter load value (iterations minus 1) |
| ec_load_en | input | 1 | Load the drain counter |
| ec_load_val | input | EC_W (6) | Drain counter load value (stage count) |
| br_done | output | 1 | Pulse: an evaluation completed last cycle |
| br_taken | output | 1 | Outcome of that evaluation |
| rot_pulse | output | 1 | Pulse: rotate the register names |
| top_pred | output | 1 | Value written to the top rotating predicate |
| lc_value | output | LC_W (64) | Current trip counter |
| ec_value | output | EC_W (6) | Current drain counter |
| rot_base | output | RB_W (7) | Current rotation base |
| stage_en | output | STAGES (8) | Stage-enable predicates after rotation |

## Verification
A corrupted counter shows up at the next evaluation. The outcome appears on br_taken and top_pred, and the counter itself is visible on lc_value or ec_value in the cycle right after the strobe. An off-by-one in the drain decision moves the fall-through one evaluation earlier or later, so the full 3/4 run counts taken outcomes and checks the final base. A broken feedback path leaves a wrong pattern in stage_en after the same run. Load priority is checked by strobing together with a load and confirming that br_done stays low.

// File: rtl/lbc_pkg.sv
// Package: shared types for the loop branch controller.
// Assumes: one evaluation per strobe; loads and strobe sampled on the same edge.
package lbc_pkg;

    typedef enum logic {
        MODE_SIMPLE = 1'b0,
        MODE_PIPE   = 1'b1
    } lbc_mode_e;

    typedef struct packed {
        logic fire;     // evaluation accepted this cycle
        logic taken;    // branch goes back to the loop top
        logic rotate;   // rename rotation requested
        logic pred;     // value for the top rotating predicate
        logic lc_dec;   // decrement trip counter
        logic ec_dec;   // decrement drain counter
    } lbc_decision_t;

endpackage

// File: rtl/lbc_down_counter.sv
// Module: loadable down-counter that saturates at zero.
// Assumes: a load wins over a decrement; a decrement at zero holds zero.
module lbc_down_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    input  logic         dec_en,
    output logic [W-1:0] value,
    output logic         is_zero
);

    localparam logic [W-1:0] ONE = W'(1);

    // Count register: reset, load, or saturating decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (load_en) begin
            value <= load_val;
        end else if (dec_en && (value != '0)) begin
            value <= value - ONE;
        end
    end

    // Zero flag used by the decision logic.
    always_comb is_zero = (value == '0);

endmodule

// File: rtl/lbc_decide.sv
// Module: combinational branch decision for both loop modes.
// Assumes: counter state is the registered value; any load cancels the evaluation.
module lbc_decide
    import lbc_pkg::*;
#(
    parameter int EC_W = 6
) (
    input  logic            br_go,
    input  lbc_mode_e       mode,
    input  logic            any_load,
    input  logic            lc_zero,
    input  logic [EC_W-1:0] ec_value,
    output lbc_decision_t   dec
);

    localparam logic [EC_W-1:0] EC_ONE = EC_W'(1);

    logic ec_above_one;

    // Drain counter still has more than the final stage left.
    always_comb ec_above_one = (ec_value > EC_ONE);

    // Choose the outcome from the mode and the counter state.
    always_comb begin
        dec = '0;
        dec.fire = br_go && !any_load;
        if (dec.fire) begin
            if (mode == MODE_PIPE) begin
                dec.rotate = 1'b1;
                if (!lc_zero) begin
                    dec.lc_dec = 1'b1;
                    dec.pred   = 1'b1;
                    dec.taken  = 1'b1;
                end else if (ec_above_one) begin
                    dec.ec_dec = 1'b1;
                    dec.taken  = 1'b1;
                end else begin
                    dec.ec_dec = 1'b1;
                end
            end else begin
                if (!lc_zero) begin
                    dec.lc_dec = 1'b1;
                    dec.taken  = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/lbc_rotator.sv
// Module: rotation base and stage-enable shift chain.
// Assumes: one rotate per cycle at most; the base wraps modulo 2^RB_W.
module lbc_rotator #(
    parameter int RB_W   = 7,
    parameter int STAGES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rotate,
    input  logic              pred_in,
    output logic [RB_W-1:0]   base,
    output logic [STAGES-1:0] stage_en
);

    localparam logic [RB_W-1:0] RB_ONE = RB_W'(1);

    // Rotation base steps down once per rotate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base <= '0;
        end else if (rotate) begin
            base <= base - RB_ONE;
        end
    end

    // Stage 0 takes the freshly written top predicate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_en[0] <= 1'b0;
        end else if (rotate) begin
            stage_en[0] <= pred_in;
        end
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Each higher stage takes its lower neighbour on a rotate.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_en[s] <= 1'b0;
            end else if (rotate) begin
                stage_en[s] <= stage_en[s-1];
            end
        end
    end

endmodule

// File: rtl/loop_branch_ctl.sv
// Module: counted loop branch controller (simple and pipelined modes).
// Assumes: br_go is a single-cycle strobe; results appear one cycle after it.
module loop_branch_ctl
    import lbc_pkg::*;
#(
    parameter int LC_W   = 64,
    parameter int EC_W   = 6,
    parameter int RB_W   = 7,
    parameter int STAGES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              br_go,
    input  logic              br_mode,
    input  logic              lc_load_en,
    input  logic [LC_W-1:0]   lc_load_val,
    input  logic              ec_load_en,
    input  logic [EC_W-1:0]   ec_load_val,
    output logic              br_done,
    output logic              br_taken,
    output logic              rot_pulse,
    output logic              top_pred,
    output logic [LC_W-1:0]   lc_value,
    output logic [EC_W-1:0]   ec_value,
    output logic [RB_W-1:0]   rot_base,
    output logic [STAGES-1:0] stage_en
);

    lbc_decision_t dec;
    lbc_mode_e     mode;
    logic          lc_zero;
    logic          ec_zero;
    logic          any_load;

    // Decode the mode pin and the load-priority condition.
    always_comb begin
        mode     = lbc_mode_e'(br_mode);
        any_load = lc_load_en || ec_load_en;
    end

    lbc_down_counter #(.W(LC_W)) u_trip (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (lc_load_en),
        .load_val (lc_load_val),
        .dec_en   (dec.lc_dec),
        .value    (lc_value),
        .is_zero  (lc_zero)
    );

    lbc_down_counter #(.W(EC_W)) u_drain (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (ec_load_en),
        .load_val (ec_load_val),
        .dec_en   (dec.ec_dec),
        .value    (ec_value),
        .is_zero  (ec_zero)
    );

    lbc_decide #(.EC_W(EC_W)) u_decide (
        .br_go    (br_go),
        .mode     (mode),
        .any_load (any_load),
        .lc_zero  (lc_zero),
        .ec_value (ec_value),
        .dec      (dec)
    );

    lbc_rotator #(.RB_W(RB_W), .STAGES(STAGES)) u_rot (
        .clk      (clk),
        .rst_n    (rst_n),
        .rotate   (dec.rotate),
        .pred_in  (dec.pred),
        .base     (rot_base),
        .stage_en (stage_en)
    );

    // Register the evaluation outcome as one-cycle result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            br_done   <= 1'b0;
            br_taken  <= 1'b0;
            rot_pulse <= 1'b0;
            top_pred  <= 1'b0;
        end else begin
            br_done   <= dec.fire;
            br_taken  <= dec.taken;
            rot_pulse <= dec.rotate;
            top_pred  <= dec.pred;
        end
    end

    logic unused_ok;
    // ec_zero is kept for observability only.
    always_comb unused_ok = ec_zero;

endmodule

// File: rtl/lbc_checker.sv
// Module: temporal checks for loop_branch_ctl, attached by bind.
// Assumes: sampled on the same clock and reset as the design.
module lbc_checker #(
    parameter int LC_W   = 64,
    parameter int EC_W   = 6,
    parameter int RB_W   = 7,
    parameter int STAGES = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              br_go,
    input logic              br_mode,
    input logic              lc_load_en,
    input logic [LC_W-1:0]   lc_load_val,
    input logic              ec_load_en,
    input logic [EC_W-1:0]   ec_load_val,
    input logic              br_done,
    input logic              br_taken,
    input logic              rot_pulse,
    input logic              top_pred,
    input logic [LC_W-1:0]   lc_value,
    input logic [EC_W-1:0]   ec_value,
    input logic [RB_W-1:0]   rot_base,
    input logic [STAGES-1:0] stage_en
);

    logic fire;
    // Accepted evaluation as seen from the ports.
    always_comb fire = br_go && !lc_load_en && !ec_load_en;

    // R2
    pipe_iter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && br_mode && (lc_value != '0)) |=>
        (lc_value == $past(lc_value) - 1'b1) && br_taken && top_pred && rot_pulse);

    // R4
    drain_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ec_load_en) |-> (ec_value <= $past(ec_value)));

    // R5
    simple_no_rot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !br_mode) |=> !rot_pulse && !top_pred && $stable(ec_value));

    // R6
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_go && lc_load_en) |=> !br_done && (lc_value == $past(lc_load_val)));

    // R7
    base_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rot_pulse |-> (rot_base == $past(rot_base) - 1'b1));

    // R8
    stage_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rot_pulse |-> (stage_en[0] == top_pred) &&
                      (stage_en[STAGES-1:1] == $past(stage_en[STAGES-2:0])));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(br_go) |-> !br_done && !br_taken && !rot_pulse);

endmodule

bind loop_branch_ctl lbc_checker #(
    .LC_W(LC_W), .EC_W(EC_W), .RB_W(RB_W), .STAGES(STAGES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .br_go(br_go), .br_mode(br_mode),
    .lc_load_en(lc_load_en), .lc_load_val(lc_load_val),
    .ec_load_en(ec_load_en), .ec_load_val(ec_load_val),
    .br_done(br_done), .br_taken(br_taken), .rot_pulse(rot_pulse),
    .top_pred(top_pred), .lc_value(lc_value), .ec_value(ec_value),
    .rot_base(rot_base), .stage_en(stage_en)
);

// File: tb/loop_branch_ctl_tb.sv
`timescale 1ns/1ps
module loop_branch_ctl_tb;

    localparam int LC_W = 64, EC_W = 6, RB_W = 7, STAGES = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              br_go = 1'b0, br_mode = 1'b0;
    logic              lc_load_en = 1'b0, ec_load_en = 1'b0;
    logic [LC_W-1:0]   lc_load_val = '0;
    logic [EC_W-1:0]   ec_load_val = '0;
    logic              br_done, br_taken, rot_pulse, top_pred;
    logic [LC_W-1:0]   lc_value;
    logic [EC_W-1:0]   ec_value;
    logic [RB_W-1:0]   rot_base;
    logic [STAGES-1:0] stage_en;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    loop_branch_ctl #(.LC_W(LC_W), .EC_W(EC_W), .RB_W(RB_W), .STAGES(STAGES)) u_dut (
        .clk(clk), .rst_n(rst_n), .br_go(br_go), .br_mode(br_mode),
        .lc_load_en(lc_load_en), .lc_load_val(lc_load_val),
        .ec_load_en(ec_load_en), .ec_load_val(ec_load_val),
        .br_done(br_done), .br_taken(br_taken), .rot_pulse(rot_pulse),
        .top_pred(top_pred), .lc_value(lc_value), .ec_value(ec_value),
        .rot_base(rot_base), .stage_en(stage_en)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Inputs change on falling edges; outputs are sampled on the next falling edge.
    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0; br_go = 0; lc_load_en = 0; ec_load_en = 0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic load(input logic [63:0] lc, input logic [5:0] ec);
        lc_load_en = 1; lc_load_val = lc; ec_load_en = 1; ec_load_val = ec;
        @(negedge clk);
        lc_load_en = 0; ec_load_en = 0;
    endtask

    task automatic eval(input logic mode);
        br_go = 1; br_mode = mode;
        @(negedge clk);
        br_go = 0;
    endtask

    task automatic t_reset();
        apply_reset();
        check("R1 lc", lc_value, 0);
        check("R1 ec", ec_value, 0);
        check("R1 base", rot_base, 0);
        check("R1 stage", stage_en, 0);
        check("R1 pulses", {br_done, br_taken, rot_pulse, top_pred}, 0);
    endtask

    task automatic t_pipe_example();
        int taken_cnt = 0;
        apply_reset();
        load(3, 4);
        for (int i = 0; i < 7; i++) begin
            eval(1'b1);
            check("R2/R3 done", br_done, 1);
            check("R8 rot", rot_pulse, 1);
            if (i < 3) begin
                check("R2 pred", top_pred, 1);
                check("R2 lc", lc_value, 2 - i);
                check("R2 ec", ec_value, 4);
            end else if (i < 6) begin
                check("R3 pred", top_pred, 0);
                check("R3 taken", br_taken, 1);
                check("R3 ec", ec_value, 6 - i);
            end else begin
                check("R4 falls", br_taken, 0);
                check("R4 ec", ec_value, 0);
            end
            if (br_taken) taken_cnt++;
        end
        check("R7 taken count", taken_cnt, 6);
        check("R7 base", rot_base, 7'h79);
        check("R7 lc end", lc_value, 0);
        check("R8 stage pattern", stage_en, 8'h70);
    endtask

    task automatic t_drain_floor();
        apply_reset();
        eval(1'b1);
        check("R4 empty falls", br_taken, 0);
        check("R4 empty rotates", rot_pulse, 1);
        check("R4 no wrap", ec_value, 0);
        check("R8 bit0", stage_en[0], 0);
    endtask

    task automatic t_simple();
        apply_reset();
        load(64'h1_0000_0000, 5);
        eval(1'b0);
        check("R5 taken", br_taken, 1);
        check("R5 lc wide", lc_value, 64'hFFFF_FFFF);
        check("R5 no rot", rot_pulse, 0);
        check("R5 ec kept", ec_value, 5);
        check("R5 base kept", rot_base, 0);
        load(1, 5);
        eval(1'b0);
        check("R5 last taken", br_taken, 1);
        eval(1'b0);
        check("R5 fall", {br_done, br_taken}, 2'b10);
        check("R5 lc zero", lc_value, 0);
    endtask

    task automatic t_load_priority();
        apply_reset();
        load(2, 3);
        br_go = 1; br_mode = 1; lc_load_en = 1; lc_load_val = 9;
        @(negedge clk);
        br_go = 0; lc_load_en = 0;
        check("R6 no done", br_done, 0);
        check("R6 lc loaded", lc_value, 9);
        check("R6 base kept", rot_base, 0);
        br_go = 1; ec_load_en = 1; ec_load_val = 6'd20;
        @(negedge clk);
        br_go = 0; ec_load_en = 0;
        check("R6 ec loaded", ec_value, 20);
        check("R6 lc not dec", lc_value, 9);
    endtask

    task automatic t_idle();
        apply_reset();
        load(4, 2);
        eval(1'b1);
        repeat (3) @(negedge clk);
        check("R9 done low", {br_done, br_taken, rot_pulse}, 0);
        check("R9 lc held", lc_value, 3);
        check("R9 base held", rot_base, 7'h7F);
        check("R9 stage held", stage_en, 8'h01);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_pipe_example();
        t_drain_floor();
        t_simple();
        t_load_priority();
        t_idle();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule